// File: doc/BRIEF.md
# Adaptive Status LED Controller

This block turns link and traffic status into drive levels for five status LEDs: a 10 Mb/s link lamp, a 100 Mb/s link lamp, a 1000 Mb/s link lamp, an activity lamp and a duplex lamp. Each LED pin doubles as a configuration strap. The level on each strap is captured while reset is held. After reset, a pin whose strap read high drives its LED active-low, and a pin whose strap read low drives it active-high. As a result, the board can use either a pull-up or a pull-down without changing the LED circuit.

Two write-only configuration registers set the display. The LED control register enables a reduced mode and can make error events modulate the activity lamp. A second register chooses how the reduced mode combines indications. In 3-in-1 mode, the 10M lamp shows a link at any speed. In 4-in-1 mode, the same lamp also shows traffic as a slow blink. Short traffic and error pulses are stretched by a prescaled timer so that they stay visible. An enabled error makes the activity lamp blink four times faster than the slow rate, and this takes priority over the normal steady activity indication.

Top module: `led_status_ctrl`

## Requirements
- R1: After reset, each `led_out[i]` equals `strap_in[i]` as sampled during reset when that LED is off, and the inverse of that level when it is lit. Strap levels that change after reset have no effect.
- R2: During and after reset, all five LEDs are off and both configuration registers read as zero, which selects standard five-LED mode with no error modulation.
- R3: LED index 0 is the 10M link, 1 is the 100M link, 2 is the 1000M link, 3 is activity and 4 is duplex. In standard mode, exactly the link LED that matches `link_speed` (0 = 10, 1 = 100, 2 = 1000) is lit while `link_up` is 1. All link LEDs are off while `link_up` is 0.
- R4: A write with `cfg_sel` = 0 sets the LED control register: bit 5 enables reduced mode, bit 3 enables idle-error modulation and bit 4 enables CRC-error modulation. A write with `cfg_sel` = 1 sets the mode register, whose bit 0 selects 4-in-1 (1) or 3-in-1 (0).
- R5: In reduced 3-in-1 mode, LED 0 is lit steadily for a link at any speed. LEDs 1 to 4 keep their standard functions.
- R6: In reduced 4-in-1 mode, LED 0 is off with no link, steady on for a link with no traffic, and blinks at the slow rate while activity is visible.
- R7: LED 3 is steadily on while `tx_act` or `rx_act` is high. After a one-cycle pulse it stays on for STRETCH_TICKS prescaler ticks, then goes off.
- R8: An idle error (when bit 3 is set) or a CRC error (when bit 4 is set) makes LED 3 blink at four times the slow rate while the error stretch timer runs. This takes priority over steady activity.
- R9: Error inputs whose modulation bit is clear have no effect on LED 3.
- R10: LED 4 is lit while `link_up` and `full_duplex` are both 1.
- R11: Every LED output is registered: an input change appears on `led_out` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| strap_in | input | 5 | Strap level read back from each LED pin |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = LED control register, 1 = mode register |
| cfg_wdata | input | 8 | Register write data |
| link_up | input | 1 | Link is established |
| link_speed | input | 2 | 0 = 10, 1 = 100, 2 = 1000 Mb/s |
| tx_act | input | 1 | Transmit activity |
| rx_act | input | 1 | Receive activity |
| full_duplex | input | 1 | Link is full duplex |
| idle_err | input | 1 | Gigabit idle error event |
| crc_err | input | 1 | CRC error event |
| led_out | output | 5 | Polarity-adapted LED drive levels |

## Verification
The assertions check several properties on every cycle. Strap levels hold steady after reset. No link lamp is lit without a link. The combined lamp is lit whenever reduced 3-in-1 mode sees a link. The activity lamp stays dark when no traffic or error timer is active. The reset image of every pin is its strap level. The bench scenarios cover the timed behaviour, which no single-cycle property can express: the stretch length, the slow blink in 4-in-1 mode, the four-times-faster error blink and its priority over traffic, and error inputs whose enable bit is clear having no effect.

// File: rtl/led_pkg.sv
package led_pkg;
  localparam int LED_N    = 5;
  localparam int IDX_L10  = 0;
  localparam int IDX_L100 = 1;
  localparam int IDX_L1G  = 2;
  localparam int IDX_ACT  = 3;
  localparam int IDX_DPX  = 4;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_RSVD = 2'd3
  } speed_e;

  // bit positions in the LED control register
  localparam int CTL_IDLE_BIT = 3;
  localparam int CTL_CRC_BIT  = 4;
  localparam int CTL_RED_BIT  = 5;
  // bit position in the mode register
  localparam int MODE_SEL_BIT = 0;
endpackage

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int DIV     = 1000,
  parameter int BLINK_W = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic slow_ph,
  output logic fast_ph
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0]      pre_q;
  logic [BLINK_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (pre_q == LAST) begin
      pre_q   <= '0;
      phase_q <= phase_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick    = (pre_q == LAST);
  assign slow_ph = phase_q[BLINK_W-1];
  assign fast_ph = phase_q[BLINK_W-3];
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trig,
  output logic busy
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (trig)
      cnt_q <= LOAD;
    else if (tick && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/led_cfg.sv
module led_cfg
  import led_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic       red_en,
  output logic       idle_mod_en,
  output logic       crc_mod_en,
  output logic       four_in_one
);
  always_ff @(posedge clk) begin
    if (rst) begin
      red_en      <= 1'b0;
      idle_mod_en <= 1'b0;
      crc_mod_en  <= 1'b0;
      four_in_one <= 1'b0;
    end else if (wr_en) begin
      if (!sel) begin
        red_en      <= wdata[CTL_RED_BIT];
        idle_mod_en <= wdata[CTL_IDLE_BIT];
        crc_mod_en  <= wdata[CTL_CRC_BIT];
      end else begin
        four_in_one <= wdata[MODE_SEL_BIT];
      end
    end
  end
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
  import led_pkg::*;
#(
  parameter int PRESCALE_DIV  = 50000,
  parameter int STRETCH_TICKS = 40,
  parameter int BLINK_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LED_N-1:0] strap_in,
  input  logic             cfg_wr_en,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  input  logic             link_up,
  input  logic [1:0]       link_speed,
  input  logic             tx_act,
  input  logic             rx_act,
  input  logic             full_duplex,
  input  logic             idle_err,
  input  logic             crc_err,
  output logic [LED_N-1:0] led_out
);
  logic [LED_N-1:0] strap_q;
  logic [LED_N-1:0] lit;
  logic             tick, slow_ph, fast_ph;
  logic             red_en, idle_mod_en, crc_mod_en, four_in_one;
  logic             act_raw, err_raw, act_busy, err_busy;
  logic             act_vis, err_vis, any_link;

  led_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .sel(cfg_sel), .wdata(cfg_wdata),
    .red_en(red_en), .idle_mod_en(idle_mod_en), .crc_mod_en(crc_mod_en),
    .four_in_one(four_in_one)
  );

  led_timebase #(.DIV(PRESCALE_DIV), .BLINK_W(BLINK_W)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .slow_ph(slow_ph), .fast_ph(fast_ph)
  );

  assign act_raw = tx_act | rx_act;
  assign err_raw = (idle_err & idle_mod_en) | (crc_err & crc_mod_en);

  led_stretch #(.TICKS(STRETCH_TICKS)) u_act_st (
    .clk(clk), .rst(rst), .tick(tick), .trig(act_raw), .busy(act_busy)
  );

  led_stretch #(.TICKS(STRETCH_TICKS)) u_err_st (
    .clk(clk), .rst(rst), .tick(tick), .trig(err_raw), .busy(err_busy)
  );

  assign act_vis  = act_raw | act_busy;
  assign err_vis  = err_raw | err_busy;
  assign any_link = link_up & (link_speed != SPD_RSVD);

  always_comb begin
    lit = '0;
    if (red_en) begin
      if (four_in_one)
        lit[IDX_L10] = any_link & (~act_vis | slow_ph);
      else
        lit[IDX_L10] = any_link;
    end else begin
      lit[IDX_L10] = link_up & (link_speed == SPD_10);
    end
    lit[IDX_L100] = link_up & (link_speed == SPD_100);
    lit[IDX_L1G]  = link_up & (link_speed == SPD_1000);
    lit[IDX_ACT]  = err_vis ? fast_ph : act_vis;
    lit[IDX_DPX]  = link_up & full_duplex;
  end

  // strap capture and polarity-adapted registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= strap_in;
      led_out <= strap_in;
    end else begin
      led_out <= lit ^ strap_q;
    end
  end
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk
  import led_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [LED_N-1:0] strap_in,
  input logic [LED_N-1:0] strap_q,
  input logic [LED_N-1:0] led_out,
  input logic             link_up,
  input logic             tx_act,
  input logic             rx_act,
  input logic             red_en,
  input logic             four_in_one,
  input logic             act_busy,
  input logic             err_busy,
  input logic             idle_err,
  input logic             crc_err
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  assert_reset_image_R2: assert property (@(posedge clk)
    seen && $past(rst) |-> led_out == $past(strap_in));

  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) |-> $stable(strap_q));

  assert_no_link_dark_R3: assert property (@(posedge clk) disable iff (rst)
    seen && $past(!link_up) |-> led_out[2:0] == strap_q[2:0]);

  assert_combined_lit_R5: assert property (@(posedge clk) disable iff (rst)
    seen && $past(red_en && !four_in_one && link_up) |->
      led_out[0] == ~strap_q[0]);

  // quiet activity lamp when no traffic, no timers and no error inputs (R7, R9)
  assert_act_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    seen && $past(!tx_act && !rx_act && !act_busy && !err_busy && !idle_err && !crc_err)
      |-> led_out[3] == strap_q[3]);
endmodule

bind led_status_ctrl led_status_chk u_chk (
  .clk(clk), .rst(rst), .strap_in(strap_in), .strap_q(strap_q),
  .led_out(led_out), .link_up(link_up), .tx_act(tx_act), .rx_act(rx_act),
  .red_en(red_en), .four_in_one(four_in_one), .act_busy(act_busy),
  .err_busy(err_busy), .idle_err(idle_err), .crc_err(crc_err)
);

// File: tb/tb_led_status_ctrl.sv
module tb_led_status_ctrl;
  localparam int DIV = 4;
  localparam int ST  = 8;
  localparam int BW  = 4;
  localparam logic [4:0] STRAP = 5'b10110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] strap_in = STRAP;
  logic cfg_wr_en = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = '0;
  logic link_up = 0, tx_act = 0, rx_act = 0, full_duplex = 0;
  logic idle_err = 0, crc_err = 0;
  logic [1:0] link_speed = 2'd0;
  logic [4:0] led_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  led_status_ctrl #(.PRESCALE_DIV(DIV), .STRETCH_TICKS(ST), .BLINK_W(BW)) dut (
    .clk(clk), .rst(rst), .strap_in(strap_in), .cfg_wr_en(cfg_wr_en),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .link_up(link_up),
    .link_speed(link_speed), .tx_act(tx_act), .rx_act(rx_act),
    .full_duplex(full_duplex), .idle_err(idle_err), .crc_err(crc_err),
    .led_out(led_out)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: led_out=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] drv(input logic [4:0] on);
    return on ^ STRAP;
  endfunction

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  // count toggles and lit samples of one LED over n cycles
  task automatic watch(input int idx, input int n, output int tog, output int ons);
    logic prev, cur;
    tog = 0; ons = 0;
    prev = led_out[idx] ^ STRAP[idx];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur = led_out[idx] ^ STRAP[idx];
      if (cur != prev) tog++;
      if (cur) ons++;
      prev = cur;
    end
  endtask

  task automatic t_reset();
    wait_n(1);
    check("R2 reset image", led_out, STRAP);
    rst = 0;
    strap_in = ~STRAP;            // later strap changes must be ignored
    wait_n(3);
    check("R1 R2 idle after reset", led_out, drv(5'b00000));
  endtask

  task automatic t_standard();
    link_up = 1; link_speed = 2'd0; wait_n(1);
    check("R11 one-edge latency 10M", led_out, drv(5'b00001));
    link_speed = 2'd1; wait_n(2);
    check("R3 100M", led_out, drv(5'b00010));
    link_speed = 2'd2; full_duplex = 1; wait_n(2);
    check("R3 R10 1000M duplex", led_out, drv(5'b10100));
    link_up = 0; wait_n(2);
    check("R3 R10 no link", led_out, drv(5'b00000));
    full_duplex = 0;
  endtask

  task automatic t_activity();
    int tg, on;
    tx_act = 1; wait_n(2);
    watch(3, 40, tg, on);
    check_int("R7 steady on with tx", tg == 0 && on == 40, on, 40);
    tx_act = 0; wait_n(1);
    rx_act = 1; wait_n(1); rx_act = 0;
    wait_n(12);
    check("R7 stretched after rx pulse", led_out, drv(5'b01000));
    wait_n(40);
    check("R7 off after stretch", led_out, drv(5'b00000));
  endtask

  task automatic t_err_disabled();
    int tg, on;
    idle_err = 1; crc_err = 1;
    watch(3, 64, tg, on);
    check_int("R9 errors without enable", on == 0, on, 0);
    idle_err = 0; crc_err = 0;
  endtask

  task automatic t_err_enabled();
    int tg, on;
    cfg_write(1'b0, 8'b0000_1000);          // idle modulation
    idle_err = 1; tx_act = 1; wait_n(2);
    watch(3, 64, tg, on);
    check_int("R8 idle fast blink over traffic", tg >= 7 && tg <= 9, tg, 8);
    idle_err = 0; tx_act = 0;
    wait_n(60);
    cfg_write(1'b0, 8'b0001_0000);          // crc only
    idle_err = 1; wait_n(2);
    watch(3, 32, tg, on);
    check_int("R9 idle ignored with only crc enabled", on == 0, on, 0);
    idle_err = 0; crc_err = 1; wait_n(2);
    watch(3, 64, tg, on);
    check_int("R4 R8 crc fast blink", tg >= 7 && tg <= 9, tg, 8);
    crc_err = 0;
    wait_n(60);
  endtask

  task automatic t_reduced3();
    cfg_write(1'b0, 8'b0010_0000);
    link_up = 1; link_speed = 2'd2; wait_n(2);
    check("R5 combined on at 1000M", led_out, drv(5'b00101));
    link_speed = 2'd1; wait_n(2);
    check("R5 combined on at 100M", led_out, drv(5'b00011));
    tx_act = 1; wait_n(2);
    check("R5 steady with traffic", led_out, drv(5'b01011));
    tx_act = 0; wait_n(60);
  endtask

  task automatic t_reduced4();
    int tg, on;
    cfg_write(1'b1, 8'h01);
    wait_n(2);
    check("R6 steady with link no traffic", led_out, drv(5'b00011));
    tx_act = 1; wait_n(2);
    watch(0, 128, tg, on);
    check_int("R6 slow blink toggles", tg >= 3 && tg <= 5, tg, 4);
    tx_act = 0; wait_n(60);
    link_up = 0; wait_n(2);
    check("R6 off without link", led_out, drv(5'b00000));
  endtask

  initial begin
    wait_n(3);
    t_reset();
    t_standard();
    t_activity();
    t_err_disabled();
    t_err_enabled();
    t_reduced3();
    t_reduced4();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule